// File: doc/BRIEF.md
# Per-Line Glitch and Debounce Input Filter Bank

This block cleans up a bank of asynchronous input lines before the rest of the chip sees them. Every line first passes through a two-flop synchronizer. It then goes through one of three paths, chosen per line at run time:

- a plain pass-through when filtering is off;
- a glitch filter that samples on every main-clock cycle;
- a debounce filter that samples on the half-period strobes of a divided slow clock.

The filtered levels come out on `line_o`. The synchronized raw levels, which show what each line carries whatever its configuration, come out on `pin_lvl_o`.

Configuration arrives through strobe words:

- Two words set and clear the per-line enable bits.
- Two more words set and clear the per-line slow-select bits.
- A divider write loads the field DIV. The divided slow clock then has a period of 2·(DIV+1) slow ticks.

The slow clock arrives as a one-cycle `slow_tick` pulse in the main clock domain. A run enable acts as the block's clock gate. While it is low, nothing moves, and the status outputs keep the levels captured when the clock was stopped.

Top module: `pin_filter_bank`

## Requirements
- R1: A 1 in `filt_set_i` sets that line's bit of `filt_en_o` on the next cycle; lines written with 0 keep their bit.
- R2: A 1 in `filt_clr_i` clears that line's bit of `filt_en_o` on the next cycle; when set and clear name the same bit in the same cycle, the set wins.
- R3: `slow_set_i` and `slow_clr_i` set and clear the bits of `slow_sel_o` in the same way (set wins); a select bit of 0 picks the glitch filter and 1 picks the debounce filter.
- R4: `pin_lvl_o` shows each input line's level two cycles after it changes, whatever the line's enable and select bits are.
- R5: A line whose enable bit is 0 drives its `line_o` bit with the input level three cycles after the input changes.
- R6: On an enabled line with select 0, a level held for only one main-clock cycle never reaches `line_o`; a level held for two or more cycles appears on `line_o` four cycles after the input change.
- R7: On an enabled line with select 1, a pulse shorter than DIV+1 slow ticks (half the divided period) never reaches `line_o`; a level held well beyond 2·(DIV+1) slow ticks is passed.
- R8: A write with `div_we_i` loads `div_o` on the next cycle and restarts the slow-tick count from zero.
- R9: While `run_en_i` is low, no output changes and all strobes, ticks and input changes are ignored; `pin_lvl_o` keeps the levels captured when it fell.
- R10: After reset, `line_o`, `pin_lvl_o`, `filt_en_o`, `slow_sel_o` and `div_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| run_en_i | input | 1 | Block clock enable; low freezes all state |
| slow_tick_i | input | 1 | One-cycle pulse per slow-clock period |
| pin_i | input | N_LINES | Raw asynchronous input lines |
| filt_set_i | input | N_LINES | Write-one-to-set strobe for enable bits |
| filt_clr_i | input | N_LINES | Write-one-to-clear strobe for enable bits |
| slow_set_i | input | N_LINES | Write-one-to-set strobe for slow-select bits |
| slow_clr_i | input | N_LINES | Write-one-to-clear strobe for slow-select bits |
| div_we_i | input | 1 | Divider field write strobe |
| div_i | input | DIV_W | Divider field write data |
| line_o | output | N_LINES | Filtered line levels |
| pin_lvl_o | output | N_LINES | Synchronized raw line levels (status read) |
| filt_en_o | output | N_LINES | Current enable bits |
| slow_sel_o | output | N_LINES | Current slow-select bits |
| div_o | output | DIV_W | Current divider field |

## Verification
All outputs are registered, so each result has a fixed latency from the negative edge where the stimulus is driven:

- configuration bits and the divider are due one cycle later;
- the status levels two cycles later;
- a pass-through line three cycles later;
- a glitch-filtered line four cycles later.

The driver pushes each expectation with its due cycle, counted from a free-running cycle counter. The monitor compares only on that exact cycle, one half period away from the active edge. Debounce results depend on where the input change falls against the strobe phase. For those, the driver queues several checks across the whole window for rejected pulses, and only a late check, well past two strobe intervals, for accepted levels.

// File: rtl/lf_pkg.sv
package lf_pkg;

  typedef enum logic [1:0] {
    LF_PASS     = 2'd0,
    LF_GLITCH   = 2'd1,
    LF_DEBOUNCE = 2'd2
  } lf_mode_e;

  function automatic lf_mode_e lf_pick_mode(input logic enable, input logic slow);
    if (!enable)   return LF_PASS;
    else if (slow) return LF_DEBOUNCE;
    else           return LF_GLITCH;
  endfunction

endpackage

// File: rtl/lf_cfg_regs.sv
module lf_cfg_regs #(
  parameter int N_LINES = 4,
  parameter int DIV_W   = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run_en,
  input  logic [N_LINES-1:0] filt_set,
  input  logic [N_LINES-1:0] filt_clr,
  input  logic [N_LINES-1:0] slow_set,
  input  logic [N_LINES-1:0] slow_clr,
  input  logic               div_we,
  input  logic [DIV_W-1:0]   div_wdata,
  output logic [N_LINES-1:0] filt_en_q,
  output logic [N_LINES-1:0] slow_sel_q,
  output logic [DIV_W-1:0]   div_q
);

  logic [N_LINES-1:0] filt_en_d;
  logic [N_LINES-1:0] slow_sel_d;
  logic [DIV_W-1:0]   div_d;

  // set has priority over clear when both name a bit
  always_comb begin
    filt_en_d  = filt_en_q;
    slow_sel_d = slow_sel_q;
    div_d      = div_q;
    if (run_en) begin
      filt_en_d  = (filt_en_q  & ~filt_clr) | filt_set;
      slow_sel_d = (slow_sel_q & ~slow_clr) | slow_set;
      if (div_we) div_d = div_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      filt_en_q  <= '0;
      slow_sel_q <= '0;
      div_q      <= '0;
    end else begin
      filt_en_q  <= filt_en_d;
      slow_sel_q <= slow_sel_d;
      div_q      <= div_d;
    end
  end

endmodule

// File: rtl/lf_slow_div.sv
module lf_slow_div #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_en,
  input  logic             slow_tick,
  input  logic [DIV_W-1:0] div_q,
  input  logic             restart,
  output logic             half_stb
);

  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] cnt_d;
  logic             wrap;

  assign wrap     = (cnt_q == div_q);
  assign half_stb = run_en & slow_tick & wrap & ~restart;

  always_comb begin
    cnt_d = cnt_q;
    if (run_en) begin
      if (restart)        cnt_d = '0;
      else if (slow_tick) cnt_d = wrap ? '0 : cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/lf_line_filter.sv
module lf_line_filter
  import lf_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     run_en,
  input  logic     pin_raw,
  input  lf_mode_e mode,
  input  logic     half_stb,
  output logic     lvl_sync,
  output logic     lvl_filt
);

  logic meta_q, sync_q, prev_q, out_q;
  logic meta_d, sync_d, prev_d, out_d;
  logic smp;

  always_comb begin
    smp = 1'b0;
    case (mode)
      LF_GLITCH:   smp = 1'b1;
      LF_DEBOUNCE: smp = half_stb;
      default:     smp = 1'b0;
    endcase
  end

  always_comb begin
    meta_d = meta_q;
    sync_d = sync_q;
    prev_d = prev_q;
    out_d  = out_q;
    if (run_en) begin
      meta_d = pin_raw;
      sync_d = meta_q;
      if (mode == LF_PASS) begin
        prev_d = sync_q;
        out_d  = sync_q;
      end else if (smp) begin
        prev_d = sync_q;
        if (sync_q == prev_q) out_d = sync_q;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
      prev_q <= 1'b0;
      out_q  <= 1'b0;
    end else begin
      meta_q <= meta_d;
      sync_q <= sync_d;
      prev_q <= prev_d;
      out_q  <= out_d;
    end
  end

  assign lvl_sync = sync_q;
  assign lvl_filt = out_q;

endmodule

// File: rtl/pin_filter_bank.sv
module pin_filter_bank
  import lf_pkg::*;
#(
  parameter int N_LINES = 4,
  parameter int DIV_W   = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run_en_i,
  input  logic               slow_tick_i,
  input  logic [N_LINES-1:0] pin_i,
  input  logic [N_LINES-1:0] filt_set_i,
  input  logic [N_LINES-1:0] filt_clr_i,
  input  logic [N_LINES-1:0] slow_set_i,
  input  logic [N_LINES-1:0] slow_clr_i,
  input  logic               div_we_i,
  input  logic [DIV_W-1:0]   div_i,
  output logic [N_LINES-1:0] line_o,
  output logic [N_LINES-1:0] pin_lvl_o,
  output logic [N_LINES-1:0] filt_en_o,
  output logic [N_LINES-1:0] slow_sel_o,
  output logic [DIV_W-1:0]   div_o
);

  localparam int RST_STAGES = 2;

  logic [RST_STAGES-1:0] rst_pipe_q;
  logic                  rst_core_n;
  logic                  half_stb;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[RST_STAGES-2:0], 1'b1};
  end
  assign rst_core_n = rst_pipe_q[RST_STAGES-1];

  lf_cfg_regs #(.N_LINES(N_LINES), .DIV_W(DIV_W)) cfg_i (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .run_en     (run_en_i),
    .filt_set   (filt_set_i),
    .filt_clr   (filt_clr_i),
    .slow_set   (slow_set_i),
    .slow_clr   (slow_clr_i),
    .div_we     (div_we_i),
    .div_wdata  (div_i),
    .filt_en_q  (filt_en_o),
    .slow_sel_q (slow_sel_o),
    .div_q      (div_o)
  );

  lf_slow_div #(.DIV_W(DIV_W)) div_i0 (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .run_en    (run_en_i),
    .slow_tick (slow_tick_i),
    .div_q     (div_o),
    .restart   (div_we_i),
    .half_stb  (half_stb)
  );

  for (genvar g = 0; g < N_LINES; g++) begin : g_line
    lf_line_filter line_i (
      .clk      (clk),
      .rst_n    (rst_core_n),
      .run_en   (run_en_i),
      .pin_raw  (pin_i[g]),
      .mode     (lf_pick_mode(filt_en_o[g], slow_sel_o[g])),
      .half_stb (half_stb),
      .lvl_sync (pin_lvl_o[g]),
      .lvl_filt (line_o[g])
    );
  end

endmodule

// File: rtl/lf_checker.sv
module lf_checker #(
  parameter int N_LINES = 4,
  parameter int DIV_W   = 8
) (
  input logic               clk,
  input logic               rst_core_n,
  input logic               run_en_i,
  input logic [N_LINES-1:0] filt_set_i,
  input logic [N_LINES-1:0] filt_clr_i,
  input logic [N_LINES-1:0] slow_set_i,
  input logic [N_LINES-1:0] slow_clr_i,
  input logic               div_we_i,
  input logic [DIV_W-1:0]   div_i,
  input logic [N_LINES-1:0] line_o,
  input logic [N_LINES-1:0] pin_lvl_o,
  input logic [N_LINES-1:0] filt_en_o,
  input logic [N_LINES-1:0] slow_sel_o,
  input logic [DIV_W-1:0]   div_o
);

  assert_filt_set_R1: assert property (@(posedge clk) disable iff (!rst_core_n)
    (run_en_i && |filt_set_i) |=> ((filt_en_o & $past(filt_set_i)) == $past(filt_set_i)));

  assert_filt_clr_R2: assert property (@(posedge clk) disable iff (!rst_core_n)
    (run_en_i && |(filt_clr_i & ~filt_set_i)) |=>
      ((filt_en_o & $past(filt_clr_i & ~filt_set_i)) == '0));

  assert_slow_set_R3: assert property (@(posedge clk) disable iff (!rst_core_n)
    (run_en_i && |slow_set_i) |=> ((slow_sel_o & $past(slow_set_i)) == $past(slow_set_i)));

  assert_slow_clr_R3: assert property (@(posedge clk) disable iff (!rst_core_n)
    (run_en_i && |(slow_clr_i & ~slow_set_i)) |=>
      ((slow_sel_o & $past(slow_clr_i & ~slow_set_i)) == '0));

  assert_pass_line_R5: assert property (@(posedge clk) disable iff (!rst_core_n)
    (run_en_i && filt_en_o == '0) |=> (line_o == $past(pin_lvl_o)));

  assert_div_load_R8: assert property (@(posedge clk) disable iff (!rst_core_n)
    (run_en_i && div_we_i) |=> (div_o == $past(div_i)));

  assert_frozen_R9: assert property (@(posedge clk) disable iff (!rst_core_n)
    !run_en_i |=> ($stable(line_o) && $stable(pin_lvl_o) && $stable(filt_en_o)
                   && $stable(slow_sel_o) && $stable(div_o)));

endmodule

bind pin_filter_bank lf_checker #(.N_LINES(N_LINES), .DIV_W(DIV_W)) chk_i (
  .clk        (clk),
  .rst_core_n (rst_core_n),
  .run_en_i   (run_en_i),
  .filt_set_i (filt_set_i),
  .filt_clr_i (filt_clr_i),
  .slow_set_i (slow_set_i),
  .slow_clr_i (slow_clr_i),
  .div_we_i   (div_we_i),
  .div_i      (div_i),
  .line_o     (line_o),
  .pin_lvl_o  (pin_lvl_o),
  .filt_en_o  (filt_en_o),
  .slow_sel_o (slow_sel_o),
  .div_o      (div_o)
);

// File: tb/pin_filter_bank_tb_top.sv
module pin_filter_bank_tb_top;

  localparam int N = 4;
  localparam int DW = 8;

  localparam int K_LINE = 0;
  localparam int K_PIN  = 1;
  localparam int K_FEN  = 2;
  localparam int K_SEL  = 3;
  localparam int K_DIV  = 4;

  typedef struct {
    int          due;
    int          kind;
    logic [31:0] exp;
    string       req;
  } item_t;

  logic          clk;
  logic          rst_n;
  logic          run_en;
  logic          slow_tick;
  logic [N-1:0]  pin;
  logic [N-1:0]  fset, fclr, sset, sclr;
  logic          div_we;
  logic [DW-1:0] div_w;
  logic [N-1:0]  line_o, pin_lvl_o, filt_en_o, slow_sel_o;
  logic [DW-1:0] div_o;

  item_t q[$];
  int    cyc = 0;
  int    n_chk = 0;
  int    n_bad = 0;
  bit    done = 0;
  bit    tick_on = 0;
  logic [N-1:0] m_fen = '0;
  logic [N-1:0] m_sel = '0;

  pin_filter_bank #(.N_LINES(N), .DIV_W(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .run_en_i(run_en), .slow_tick_i(slow_tick),
    .pin_i(pin), .filt_set_i(fset), .filt_clr_i(fclr), .slow_set_i(sset),
    .slow_clr_i(sclr), .div_we_i(div_we), .div_i(div_w), .line_o(line_o),
    .pin_lvl_o(pin_lvl_o), .filt_en_o(filt_en_o), .slow_sel_o(slow_sel_o),
    .div_o(div_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic expect_at(input int dly, input int kind, input logic [31:0] v, input string req);
    item_t it;
    it.due = cyc + dly; it.kind = kind; it.exp = v; it.req = req;
    q.push_back(it);
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  // write strobes for one cycle, expected bits from the set/clear rule
  task automatic wr_bits(input logic [N-1:0] fs, input logic [N-1:0] fc,
                         input logic [N-1:0] ss, input logic [N-1:0] sc, input string req);
    fset = fs; fclr = fc; sset = ss; sclr = sc;
    m_fen = (m_fen & ~fc) | fs;
    m_sel = (m_sel & ~sc) | ss;
    expect_at(1, K_FEN, 32'(m_fen), req);
    expect_at(1, K_SEL, 32'(m_sel), req);
    step(1);
    fset = '0; fclr = '0; sset = '0; sclr = '0;
  endtask

  // monitor: compares each queued item in its due cycle, away from the edge
  always @(negedge clk) begin
    for (int i = q.size() - 1; i >= 0; i--) begin
      if (q[i].due == cyc) begin
        logic [31:0] act;
        case (q[i].kind)
          K_LINE:  act = 32'(line_o);
          K_PIN:   act = 32'(pin_lvl_o);
          K_FEN:   act = 32'(filt_en_o);
          K_SEL:   act = 32'(slow_sel_o);
          default: act = 32'(div_o);
        endcase
        n_chk++;
        if (act !== q[i].exp) begin
          n_bad++;
          $display("FAIL %s kind=%0d cyc=%0d actual=%h expected=%h",
                   q[i].req, q[i].kind, cyc, act, q[i].exp);
        end
        q.delete(i);
      end
    end
  end

  // slow tick every 4 main cycles
  initial begin
    slow_tick = 1'b0;
    forever begin
      @(negedge clk);
      slow_tick = tick_on && (cyc % 4 == 0);
    end
  end

  initial begin
    rst_n = 1'b0; run_en = 1'b1; pin = '0;
    fset = '0; fclr = '0; sset = '0; sclr = '0; div_we = 1'b0; div_w = '0;
    step(3);
    rst_n = 1'b1;
    step(4);
    // R10 reset state
    expect_at(1, K_LINE, 0, "R10");
    expect_at(1, K_PIN,  0, "R10");
    expect_at(1, K_FEN,  0, "R10");
    expect_at(1, K_SEL,  0, "R10");
    expect_at(1, K_DIV,  0, "R10");
    step(2);

    // R1: set bits, zeros leave others alone
    wr_bits(4'b0110, 4'b0000, 4'b0000, 4'b0000, "R1");
    wr_bits(4'b0001, 4'b0000, 4'b0000, 4'b0000, "R1");
    // R2: set wins over clear on the same bit, then a plain clear
    wr_bits(4'b0100, 4'b0100, 4'b0000, 4'b0000, "R2");
    wr_bits(4'b0000, 4'b0001, 4'b0000, 4'b0000, "R2");
    // R3: slow select set/clear; line2 ends up on the debounce filter
    wr_bits(4'b0000, 4'b0000, 4'b1100, 4'b0000, "R3");
    wr_bits(4'b0000, 4'b0000, 4'b0000, 4'b1000, "R3");
    wr_bits(4'b0000, 4'b0000, 4'b0010, 4'b0010, "R3");
    wr_bits(4'b0000, 4'b0000, 4'b0000, 4'b0010, "R3");
    // config now: enable 0110, select 0100 -> line0/3 pass, line1 glitch, line2 debounce

    // R8: divider load, then slow ticks start
    div_we = 1'b1; div_w = 8'd1;
    expect_at(1, K_DIV, 1, "R8");
    step(1);
    div_we = 1'b0;
    tick_on = 1'b1;
    step(4);

    // R4 and R5: pass-through lines
    pin = 4'b1001;
    expect_at(2, K_PIN,  32'h9, "R4");
    expect_at(2, K_LINE, 32'h0, "R5");
    expect_at(3, K_LINE, 32'h9, "R5");
    step(6);

    // R6: one-cycle glitch on line1 is dropped
    pin = 4'b1011;
    expect_at(2, K_PIN, 32'hB, "R4");
    for (int d = 3; d <= 7; d++) expect_at(d, K_LINE, 32'h9, "R6");
    step(1);
    pin = 4'b1001;
    step(8);
    // R6: held level on line1 passes after four cycles
    pin = 4'b1011;
    expect_at(3, K_LINE, 32'h9, "R6");
    expect_at(4, K_LINE, 32'hB, "R6");
    step(8);
    pin = 4'b1001;
    expect_at(3, K_LINE, 32'hB, "R6");
    expect_at(4, K_LINE, 32'h9, "R6");
    step(8);

    // R7: 3-cycle pulse on line2 is shorter than half the divided period (8 cycles)
    pin = 4'b1101;
    expect_at(2, K_PIN, 32'hD, "R4");
    for (int d = 4; d <= 28; d += 4) expect_at(d, K_LINE, 32'h9, "R7");
    step(3);
    pin = 4'b1001;
    step(30);
    // R7: long level passes
    pin = 4'b1101;
    expect_at(32, K_LINE, 32'hD, "R7");
    step(40);
    pin = 4'b1001;
    expect_at(32, K_LINE, 32'h9, "R7");
    step(40);

    // R9: clock stopped - nothing moves
    run_en = 1'b0;
    pin = 4'b0110;
    fset = 4'b0001;
    expect_at(2, K_FEN,  32'h6, "R9");
    expect_at(3, K_PIN,  32'h9, "R9");
    expect_at(3, K_LINE, 32'h9, "R9");
    expect_at(8, K_PIN,  32'h9, "R9");
    expect_at(8, K_LINE, 32'h9, "R9");
    step(1);
    fset = '0;
    step(9);
    run_en = 1'b1;
    expect_at(2, K_PIN, 32'h6, "R4");
    expect_at(2, K_FEN, 32'h6, "R9");
    expect_at(32, K_LINE, 32'h6, "R7");
    step(40);

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule